// File: doc/BRIEF.md
# D-PHY Lane Timing Counter Calculator

This block turns a set of link timing requirements into the counter values that program the per-lane sequencers of a D-PHY transmitter. Software, or a power-up sequencer, presents the achieved PLL output rate in hertz, the requested durations in picoseconds, the clock-pre requirement in bit periods, and a select that picks one of two timing tables. The first table covers links of up to 1 GHz and the second covers links of up to 2.5 GHz. A one-cycle `start` pulse latches all of these inputs and begins the computation.

The byte clock is the PLL rate divided by eight. From it the block derives the byte-clock period, an escape-clock divider that keeps the escape clock at or below 20 MHz, the escape clock itself and the escape-clock period. Each duration is then converted to a count by ceiling division against the matching period. All of these divisions run one after another on a single shared bit-serial divider. Prepare, trail and HS-zero values come from a rate-indexed table. The results are cut into the low and high register fields that the lane registers expect.

When the computation finishes, the fields are held in output registers and `done` pulses for one cycle. A PLL rate too small to give a nonzero byte clock stops the computation with an error.

Top module: `dphy_tc_calc`

## Requirements
- R1: The table row used is the first row, in ascending rate order, whose rate is greater than or equal to `pll_rate`. When no row qualifies, the last row is used. The low-rate table (`rate_sel`=0) has 11 rows, from 110 MHz to 1 GHz. The high-rate table (`rate_sel`=1) has 19 rows, from 110 MHz to 2.5 GHz.
- R2: The byte clock is BC = floor(pll_rate/8) and the byte period is TB = floor(10^12/BC) ps. The HS-exit count is ceil(hs_exit_ps/TB) and the clock-post count is ceil(clk_post_ps/TB).
- R3: The escape divider is ED = ceil(BC/20000000), the escape clock is EC = floor(BC/ED) and the escape period is TE = floor(10^12/EC). The turnaround go, sure and wait counts are ceil(duration/TE), each kept in 6 bits.
- R4: The clock-pre count is the low 4 bits of ceil(clk_pre_ui/8).
- R5: With `rate_sel`=0 the LPX count is V = ceil(lpx_ps/TB), lowered by 2 only when V >= 2, and kept in 6 bits. With `rate_sel`=1 the LPX count is the table value and `lpx_ps` has no effect.
- R6: The clock-lane HS-zero fields carry the row's clock-lane value and the data-lane HS-zero fields carry the row's data-lane value. `hs_prep_cnt` and `trail_cnt` carry the row's prepare and trail values.
- R7: With `rate_sel`=1, bit 6 of each HS-zero value goes to its `_hi` output and bits 5:0 go to `_lo`. HS-exit bit 5 goes to `exit_hi` and bits 4:0 go to `exit_lo`. Clock-post bits 5:4 go to `post_hi` and bits 3:0 go to `post_lo`. With `rate_sel`=0 every `_hi` output is 0 and the `_lo` outputs keep the same low bits.
- R8: On a successful computation the wake-up count 0x3FF is presented as `wake_hi`=2'b11 and `wake_lo`=8'hFF.
- R9: `start` while idle raises `busy` on the next cycle. `done` is a single-cycle pulse during which `busy` is low. All count outputs change only in the cycle in which `done` is high.
- R10: When `pll_rate` is below 8, so that the byte clock is zero, `done` rises with `err`=1 and every count output is 0. `err` is 0 after any successful computation.
- R11: A `start` pulse that arrives while `busy` is high is ignored, and the results belong to the inputs latched by the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch inputs and begin a computation (idle only) |
| rate_sel | input | 1 | Timing table select: 0 = up to 1 GHz, 1 = up to 2.5 GHz |
| pll_rate | input | 32 | Achieved PLL output rate in Hz |
| hs_exit_ps | input | 32 | Required HS-exit time, ps |
| clk_post_ps | input | 32 | Required clock-post time, ps |
| clk_pre_ui | input | 32 | Required clock-pre time in bit periods |
| lpx_ps | input | 32 | Required LPX time, ps |
| ta_go_ps | input | 32 | Required turnaround-go time, ps |
| ta_sure_ps | input | 32 | Required turnaround-sure time, ps |
| ta_wait_ps | input | 32 | Required turnaround-wait time, ps |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last computation failed (zero byte clock) |
| lpx_cnt | output | 6 | LPX count |
| hs_prep_cnt | output | 7 | HS-prepare count |
| clk_zero_hi | output | 1 | Clock-lane HS-zero bit 6 |
| clk_zero_lo | output | 6 | Clock-lane HS-zero bits 5:0 |
| dat_zero_hi | output | 1 | Data-lane HS-zero bit 6 |
| dat_zero_lo | output | 6 | Data-lane HS-zero bits 5:0 |
| trail_cnt | output | 7 | HS-trail count |
| exit_hi | output | 1 | HS-exit bit 5 |
| exit_lo | output | 5 | HS-exit bits 4:0 |
| post_hi | output | 2 | Clock-post bits 5:4 |
| post_lo | output | 4 | Clock-post bits 3:0 |
| pre_cnt | output | 4 | Clock-pre count |
| wake_hi | output | 2 | Wake-up count bits 9:8 |
| wake_lo | output | 8 | Wake-up count bits 7:0 |
| ta_go_cnt | output | 6 | Turnaround-go count |
| ta_sure_cnt | output | 6 | Turnaround-sure count |
| ta_wait_cnt | output | 6 | Turnaround-wait count |

## Verification
The embedded assertions check on every cycle the handshake rules: `done` lasts one cycle, `busy` is low while `done` is high, and the count outputs stay frozen outside the `done` cycle. They also check that the `_hi` fields are zero in the low-rate variant, that an error yields all-zero counts, and that the divider answers a zero divisor in one cycle. The arithmetic itself can only be shown by the directed scenarios. These cover row selection at an exact match, between two rows, below the first row and above the last row, the ceiling divisions and escape-clock derivation, the LPX offset on both sides of 2, the field splits in both variants, the zero-byte-clock error, and a second start pulse during a computation.

// File: rtl/dphy_tc_pkg.sv
package dphy_tc_pkg;

    localparam int RATE_W    = 32;
    localparam int DUR_W     = 32;
    localparam int DIV_W     = 40;
    localparam int N_ROWS_LO = 11;
    localparam int N_ROWS_HI = 19;
    localparam int N_OPS     = 10;
    localparam logic [DIV_W-1:0] PS_PER_SEC  = 40'd1_000_000_000_000;
    localparam logic [DIV_W-1:0] ESC_MAX_HZ  = 40'd20_000_000;
    localparam logic [9:0]       WAKE_COUNT  = 10'h3FF;

    typedef struct packed {
        logic [5:0] lpx;
        logic [6:0] prep;
        logic [6:0] clk_zero;
        logic [6:0] dat_zero;
        logic [6:0] trail;
    } tm_t;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        tm_t               tm;
    } row_t;

    typedef struct packed {
        logic [5:0] lpx;
        logic [6:0] prep;
        logic       cz_hi;
        logic [5:0] cz_lo;
        logic       dz_hi;
        logic [5:0] dz_lo;
        logic [6:0] trail;
        logic       ex_hi;
        logic [4:0] ex_lo;
        logic [1:0] po_hi;
        logic [3:0] po_lo;
        logic [3:0] pre;
        logic [1:0] wk_hi;
        logic [7:0] wk_lo;
        logic [5:0] ta_go;
        logic [5:0] ta_sure;
        logic [5:0] ta_wait;
    } fld_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} st_t;

    typedef enum logic [3:0] {
        OP_TBYTE, OP_ESCDIV, OP_ESCCLK, OP_TESC,
        OP_EXIT, OP_POST, OP_LPX, OP_TAGO, OP_TASURE, OP_TAWAIT
    } op_t;

    function automatic row_t mk(input logic [31:0] r, input logic [5:0] l,
                                input logic [6:0] p, input logic [6:0] c,
                                input logic [6:0] d, input logic [6:0] t);
        row_t x;
        x.rate = r; x.tm.lpx = l; x.tm.prep = p;
        x.tm.clk_zero = c; x.tm.dat_zero = d; x.tm.trail = t;
        return x;
    endfunction

    function automatic row_t row_lo(input int i);
        case (i)
            0:       return mk(32'd110000000,  6'h0, 7'h20, 7'h16, 7'h02, 7'h22);
            1:       return mk(32'd150000000,  6'h0, 7'h06, 7'h16, 7'h03, 7'h45);
            2:       return mk(32'd200000000,  6'h0, 7'h18, 7'h17, 7'h04, 7'h0b);
            3:       return mk(32'd250000000,  6'h0, 7'h05, 7'h17, 7'h05, 7'h16);
            4:       return mk(32'd300000000,  6'h0, 7'h51, 7'h18, 7'h06, 7'h2c);
            5:       return mk(32'd400000000,  6'h0, 7'h64, 7'h19, 7'h07, 7'h33);
            6:       return mk(32'd500000000,  6'h0, 7'h20, 7'h1b, 7'h07, 7'h4e);
            7:       return mk(32'd600000000,  6'h0, 7'h6a, 7'h1d, 7'h08, 7'h3a);
            8:       return mk(32'd700000000,  6'h0, 7'h3e, 7'h1e, 7'h08, 7'h6a);
            9:       return mk(32'd800000000,  6'h0, 7'h21, 7'h1f, 7'h09, 7'h29);
            default: return mk(32'd1000000000, 6'h0, 7'h09, 7'h20, 7'h09, 7'h27);
        endcase
    endfunction

    function automatic row_t row_hi(input int i);
        case (i)
            0:       return mk(32'd110000000,  6'h02, 7'h7f, 7'h16, 7'h02, 7'h02);
            1:       return mk(32'd150000000,  6'h02, 7'h7f, 7'h16, 7'h03, 7'h02);
            2:       return mk(32'd200000000,  6'h02, 7'h7f, 7'h17, 7'h04, 7'h02);
            3:       return mk(32'd250000000,  6'h02, 7'h7f, 7'h17, 7'h05, 7'h04);
            4:       return mk(32'd300000000,  6'h02, 7'h7f, 7'h18, 7'h06, 7'h04);
            5:       return mk(32'd400000000,  6'h03, 7'h7e, 7'h19, 7'h07, 7'h04);
            6:       return mk(32'd500000000,  6'h03, 7'h7c, 7'h1b, 7'h07, 7'h08);
            7:       return mk(32'd600000000,  6'h03, 7'h70, 7'h1d, 7'h08, 7'h10);
            8:       return mk(32'd700000000,  6'h05, 7'h40, 7'h1e, 7'h08, 7'h30);
            9:       return mk(32'd800000000,  6'h05, 7'h02, 7'h1f, 7'h09, 7'h30);
            10:      return mk(32'd1000000000, 6'h05, 7'h08, 7'h20, 7'h09, 7'h30);
            11:      return mk(32'd1200000000, 6'h06, 7'h03, 7'h32, 7'h14, 7'h0f);
            12:      return mk(32'd1400000000, 6'h09, 7'h03, 7'h32, 7'h14, 7'h0f);
            13:      return mk(32'd1600000000, 6'h0d, 7'h42, 7'h36, 7'h0e, 7'h0f);
            14:      return mk(32'd1800000000, 6'h0e, 7'h47, 7'h7a, 7'h0e, 7'h0f);
            15:      return mk(32'd2000000000, 6'h11, 7'h64, 7'h7a, 7'h0e, 7'h0b);
            16:      return mk(32'd2200000000, 6'h13, 7'h64, 7'h7e, 7'h15, 7'h0b);
            17:      return mk(32'd2400000000, 6'h13, 7'h33, 7'h7f, 7'h15, 7'h6a);
            default: return mk(32'd2500000000, 6'h15, 7'h54, 7'h7f, 7'h15, 7'h6a);
        endcase
    endfunction

endpackage

// File: rtl/dphy_tc_divider.sv
module dphy_tc_divider
    import dphy_tc_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         ceil_en,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         dz,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, q_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          ceil_q;
    logic [W:0]    trial;
    logic          fits;
    logic [W-1:0]  rem_next;
    logic [W-1:0]  q_next;

    always_comb begin
        trial    = {rem_q, q_q[W-1]};
        fits     = trial >= {1'b0, dvs_q};
        rem_next = fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
        q_next   = {q_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0; q_q <= '0; dvs_q <= '0; cnt_q <= '0;
            ceil_q <= 1'b0; busy <= 1'b0; done <= 1'b0; dz <= 1'b0; quot <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                if (divisor == '0) begin
                    done <= 1'b1;
                    dz   <= 1'b1;
                    quot <= '0;
                end else begin
                    busy   <= 1'b1;
                    dz     <= 1'b0;
                    rem_q  <= '0;
                    q_q    <= dividend;
                    dvs_q  <= divisor;
                    ceil_q <= ceil_en;
                    cnt_q  <= CW'(W);
                end
            end else if (busy) begin
                rem_q <= rem_next;
                q_q   <= q_next;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quot <= q_next + W'(ceil_q && (rem_next != '0));
                end
            end
        end
    end

    // R10: a zero divisor is answered on the next cycle with the flag set
    a_r10_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (go && !busy && divisor == '0) |=> (done && dz));

    // R9: no result while the shift loop is still running
    a_r9_no_early_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);
endmodule

// File: rtl/dphy_tc_rowsel.sv
module dphy_tc_rowsel
    import dphy_tc_pkg::*;
(
    input  logic              rate_sel,
    input  logic [RATE_W-1:0] rate,
    output tm_t               tm
);
    always_comb begin
        row_t r;
        logic found;
        int   n;
        n     = rate_sel ? N_ROWS_HI : N_ROWS_LO;
        found = 1'b0;
        tm    = rate_sel ? row_hi(N_ROWS_HI - 1).tm : row_lo(N_ROWS_LO - 1).tm;
        for (int i = 0; i < N_ROWS_HI; i++) begin
            r = rate_sel ? row_hi(i) : row_lo(i);
            if (i < n && !found && rate <= r.rate) begin
                tm    = r.tm;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dphy_tc_fields.sv
module dphy_tc_fields
    import dphy_tc_pkg::*;
(
    input  logic             rate_sel,
    input  tm_t              tm,
    input  logic [5:0]       exit_v,
    input  logic [5:0]       post_v,
    input  logic [DIV_W-1:0] lpx_v,
    input  logic [DUR_W-1:0] pre_ui,
    input  logic [5:0]       ta_go_v,
    input  logic [5:0]       ta_sure_v,
    input  logic [5:0]       ta_wait_v,
    output fld_t             f
);
    logic [DUR_W:0]   pre_c;
    logic [DIV_W-1:0] lpx_adj;

    always_comb begin
        pre_c   = ({1'b0, pre_ui} + (DUR_W+1)'(7)) >> 3;
        lpx_adj = (lpx_v >= DIV_W'(2)) ? lpx_v - DIV_W'(2) : lpx_v;

        f.lpx     = rate_sel ? tm.lpx : lpx_adj[5:0];
        f.prep    = tm.prep;
        f.cz_hi   = rate_sel & tm.clk_zero[6];
        f.cz_lo   = tm.clk_zero[5:0];
        f.dz_hi   = rate_sel & tm.dat_zero[6];
        f.dz_lo   = tm.dat_zero[5:0];
        f.trail   = tm.trail;
        f.ex_hi   = rate_sel & exit_v[5];
        f.ex_lo   = exit_v[4:0];
        f.po_hi   = rate_sel ? post_v[5:4] : 2'b00;
        f.po_lo   = post_v[3:0];
        f.pre     = pre_c[3:0];
        f.wk_hi   = WAKE_COUNT[9:8];
        f.wk_lo   = WAKE_COUNT[7:0];
        f.ta_go   = ta_go_v;
        f.ta_sure = ta_sure_v;
        f.ta_wait = ta_wait_v;
    end
endmodule

// File: rtl/dphy_tc_calc.sv
module dphy_tc_calc
    import dphy_tc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rate_sel,
    input  logic [31:0] pll_rate,
    input  logic [31:0] hs_exit_ps,
    input  logic [31:0] clk_post_ps,
    input  logic [31:0] clk_pre_ui,
    input  logic [31:0] lpx_ps,
    input  logic [31:0] ta_go_ps,
    input  logic [31:0] ta_sure_ps,
    input  logic [31:0] ta_wait_ps,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [5:0]  lpx_cnt,
    output logic [6:0]  hs_prep_cnt,
    output logic        clk_zero_hi,
    output logic [5:0]  clk_zero_lo,
    output logic        dat_zero_hi,
    output logic [5:0]  dat_zero_lo,
    output logic [6:0]  trail_cnt,
    output logic        exit_hi,
    output logic [4:0]  exit_lo,
    output logic [1:0]  post_hi,
    output logic [3:0]  post_lo,
    output logic [3:0]  pre_cnt,
    output logic [1:0]  wake_hi,
    output logic [7:0]  wake_lo,
    output logic [5:0]  ta_go_cnt,
    output logic [5:0]  ta_sure_cnt,
    output logic [5:0]  ta_wait_cnt
);
    st_t               st_q;
    op_t               op_q;
    logic              sel_q, err_q;
    logic [RATE_W-1:0] rate_q;
    logic [DUR_W-1:0]  exit_q, post_q, pre_q, lpx_q, go_q, sure_q, wait_q;
    logic [DIV_W-1:0]  res_q [N_OPS];
    fld_t              fld_q, fld_c;
    tm_t               tm_c;

    logic              div_go, div_ceil, div_busy, div_done, div_dz;
    logic [DIV_W-1:0]  div_num, div_den, div_quot, byte_clk;

    assign byte_clk = DIV_W'(rate_q >> 3);
    assign div_go   = (st_q == ST_ISSUE);

    always_comb begin
        div_num  = PS_PER_SEC;
        div_den  = byte_clk;
        div_ceil = 1'b1;
        case (op_q)
            OP_TBYTE:  div_ceil = 1'b0;
            OP_ESCDIV: begin div_num = byte_clk; div_den = ESC_MAX_HZ; end
            OP_ESCCLK: begin div_num = byte_clk; div_den = res_q[OP_ESCDIV]; div_ceil = 1'b0; end
            OP_TESC:   begin div_den = res_q[OP_ESCCLK]; div_ceil = 1'b0; end
            OP_EXIT:   begin div_num = DIV_W'(exit_q); div_den = res_q[OP_TBYTE]; end
            OP_POST:   begin div_num = DIV_W'(post_q); div_den = res_q[OP_TBYTE]; end
            OP_LPX:    begin div_num = DIV_W'(lpx_q);  div_den = res_q[OP_TBYTE]; end
            OP_TAGO:   begin div_num = DIV_W'(go_q);   div_den = res_q[OP_TESC]; end
            OP_TASURE: begin div_num = DIV_W'(sure_q); div_den = res_q[OP_TESC]; end
            default:   begin div_num = DIV_W'(wait_q); div_den = res_q[OP_TESC]; end
        endcase
    end

    dphy_tc_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .ceil_en(div_ceil),
        .dividend(div_num), .divisor(div_den),
        .busy(div_busy), .done(div_done), .dz(div_dz), .quot(div_quot)
    );

    dphy_tc_rowsel u_rowsel (.rate_sel(sel_q), .rate(rate_q), .tm(tm_c));

    dphy_tc_fields u_fields (
        .rate_sel(sel_q), .tm(tm_c),
        .exit_v(res_q[OP_EXIT][5:0]), .post_v(res_q[OP_POST][5:0]),
        .lpx_v(res_q[OP_LPX]), .pre_ui(pre_q),
        .ta_go_v(res_q[OP_TAGO][5:0]), .ta_sure_v(res_q[OP_TASURE][5:0]),
        .ta_wait_v(res_q[OP_TAWAIT][5:0]), .f(fld_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE; op_q <= OP_TBYTE; sel_q <= 1'b0; err_q <= 1'b0;
            rate_q <= '0; exit_q <= '0; post_q <= '0; pre_q <= '0;
            lpx_q <= '0; go_q <= '0; sure_q <= '0; wait_q <= '0;
            for (int i = 0; i < N_OPS; i++) res_q[i] <= '0;
            fld_q <= '0; done <= 1'b0; err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    sel_q <= rate_sel; rate_q <= pll_rate;
                    exit_q <= hs_exit_ps; post_q <= clk_post_ps; pre_q <= clk_pre_ui;
                    lpx_q <= lpx_ps; go_q <= ta_go_ps; sure_q <= ta_sure_ps;
                    wait_q <= ta_wait_ps; op_q <= OP_TBYTE; err_q <= 1'b0;
                    st_q <= ST_ISSUE;
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: if (div_done) begin
                    if (div_dz) begin
                        err_q <= 1'b1;
                        st_q  <= ST_FIN;
                    end else begin
                        res_q[op_q] <= div_quot;
                        if (op_q == OP_TAWAIT) st_q <= ST_FIN;
                        else begin
                            op_q <= op_t'(op_q + 1'b1);
                            st_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    fld_q <= err_q ? '0 : fld_c;
                    err   <= err_q;
                    done  <= 1'b1;
                    st_q  <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy        = (st_q != ST_IDLE);
    assign lpx_cnt     = fld_q.lpx;
    assign hs_prep_cnt = fld_q.prep;
    assign clk_zero_hi = fld_q.cz_hi;
    assign clk_zero_lo = fld_q.cz_lo;
    assign dat_zero_hi = fld_q.dz_hi;
    assign dat_zero_lo = fld_q.dz_lo;
    assign trail_cnt   = fld_q.trail;
    assign exit_hi     = fld_q.ex_hi;
    assign exit_lo     = fld_q.ex_lo;
    assign post_hi     = fld_q.po_hi;
    assign post_lo     = fld_q.po_lo;
    assign pre_cnt     = fld_q.pre;
    assign wake_hi     = fld_q.wk_hi;
    assign wake_lo     = fld_q.wk_lo;
    assign ta_go_cnt   = fld_q.ta_go;
    assign ta_sure_cnt = fld_q.ta_sure;
    assign ta_wait_cnt = fld_q.ta_wait;

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: busy is never high together with done
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: count outputs move only in the done cycle
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(fld_q));

    // R7: the low-rate variant leaves all high fields at zero
    a_r7_hi_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !sel_q) |-> (!clk_zero_hi && !dat_zero_hi && !exit_hi && post_hi == 2'b00));

    // R10: a failed computation presents all-zero counts
    a_r10_err_zero: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (lpx_cnt == '0 && ta_go_cnt == '0 && wake_lo == '0 && hs_prep_cnt == '0));
endmodule

// File: tb/dphy_tc_calc_bench.sv
`timescale 1ns/1ps
module dphy_tc_calc_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rate_sel = 1'b0;
    logic [31:0] pll_rate = '0, hs_exit_ps = '0, clk_post_ps = '0, clk_pre_ui = '0;
    logic [31:0] lpx_ps = '0, ta_go_ps = '0, ta_sure_ps = '0, ta_wait_ps = '0;
    logic        busy, done, err;
    logic [5:0]  lpx_cnt, clk_zero_lo, dat_zero_lo, ta_go_cnt, ta_sure_cnt, ta_wait_cnt;
    logic [6:0]  hs_prep_cnt, trail_cnt;
    logic        clk_zero_hi, dat_zero_hi, exit_hi;
    logic [4:0]  exit_lo;
    logic [1:0]  post_hi, wake_hi;
    logic [3:0]  post_lo, pre_cnt;
    logic [7:0]  wake_lo;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dphy_tc_calc u_dphy_tc_calc (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] cdiv(input logic [63:0] a, input logic [63:0] b);
        return (a + b - 1) / b;
    endfunction

    task automatic set_inputs(input logic sel, input logic [31:0] rate,
                              input logic [31:0] ex, input logic [31:0] po,
                              input logic [31:0] pr, input logic [31:0] lp,
                              input logic [31:0] tg, input logic [31:0] ts,
                              input logic [31:0] tw);
        rate_sel = sel; pll_rate = rate; hs_exit_ps = ex; clk_post_ps = po;
        clk_pre_ui = pr; lpx_ps = lp; ta_go_ps = tg; ta_sure_ps = ts; ta_wait_ps = tw;
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done;
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "done seen before timeout", 64'(n < 3000), 64'd1);
    endtask

    // Compare outputs (sampled in the done cycle) with the requirement formulas
    task automatic check_result(input string name, input logic sel, input logic [31:0] rate,
                                input logic [31:0] ex, input logic [31:0] po,
                                input logic [31:0] pr, input logic [31:0] lp,
                                input logic [31:0] tg, input logic [31:0] ts,
                                input logic [31:0] tw,
                                input logic [63:0] r_lpx, input logic [63:0] r_prep,
                                input logic [63:0] r_cz, input logic [63:0] r_dz,
                                input logic [63:0] r_tr);
        logic [63:0] bc, tb, ed, ec, te, e_ex, e_po, e_lp;
        bc = rate / 8;
        tb = 64'd1000000000000 / bc;
        ed = cdiv(bc, 64'd20000000);
        ec = bc / ed;
        te = 64'd1000000000000 / ec;
        e_ex = cdiv(ex, tb);
        e_po = cdiv(po, tb);
        e_lp = cdiv(lp, tb);
        if (e_lp >= 2) e_lp = e_lp - 2;
        $display("case %s", name);
        chk("R9",  "busy low at done", busy, 0);
        chk("R10", "err clear on success", err, 0);
        chk("R5",  "lpx count", lpx_cnt, sel ? r_lpx : (e_lp & 63));
        chk("R6",  "prepare", hs_prep_cnt, r_prep);
        chk("R6",  "trail", trail_cnt, r_tr);
        chk("R6",  "clock lane zero lo", clk_zero_lo, r_cz & 63);
        chk("R6",  "data lane zero lo", dat_zero_lo, r_dz & 63);
        chk("R7",  "clock lane zero hi", clk_zero_hi, sel ? (r_cz >> 6) & 1 : 0);
        chk("R7",  "data lane zero hi", dat_zero_hi, sel ? (r_dz >> 6) & 1 : 0);
        chk("R2",  "exit lo", exit_lo, e_ex & 31);
        chk("R7",  "exit hi", exit_hi, sel ? (e_ex >> 5) & 1 : 0);
        chk("R2",  "post lo", post_lo, e_po & 15);
        chk("R7",  "post hi", post_hi, sel ? (e_po >> 4) & 3 : 0);
        chk("R4",  "clock pre", pre_cnt, cdiv(pr, 8) & 15);
        chk("R8",  "wake hi", wake_hi, 3);
        chk("R8",  "wake lo", wake_lo, 255);
        chk("R3",  "ta go", ta_go_cnt, cdiv(tg, te) & 63);
        chk("R3",  "ta sure", ta_sure_cnt, cdiv(ts, te) & 63);
        chk("R3",  "ta wait", ta_wait_cnt, cdiv(tw, te) & 63);
        @(negedge clk);
        chk("R9",  "done one cycle", done, 0);
        chk("R9",  "lpx held after done", lpx_cnt, sel ? r_lpx : (e_lp & 63));
    endtask

    task automatic run_case(input string name, input logic sel, input logic [31:0] rate,
                            input logic [31:0] ex, input logic [31:0] po,
                            input logic [31:0] pr, input logic [31:0] lp,
                            input logic [31:0] tg, input logic [31:0] ts,
                            input logic [31:0] tw,
                            input logic [63:0] r_lpx, input logic [63:0] r_prep,
                            input logic [63:0] r_cz, input logic [63:0] r_dz,
                            input logic [63:0] r_tr);
        set_inputs(sel, rate, ex, po, pr, lp, tg, ts, tw);
        pulse_start();
        chk("R9", "busy after start", busy, 1);
        wait_done();
        check_result(name, sel, rate, ex, po, pr, lp, tg, ts, tw,
                     r_lpx, r_prep, r_cz, r_dz, r_tr);
    endtask

    task automatic t_reset;
        chk("R9", "reset busy", busy, 0);
        chk("R9", "reset done", done, 0);
        chk("R10", "reset err", err, 0);
        chk("R8", "reset wake lo", wake_lo, 0);
    endtask

    // R10: byte clock of zero
    task automatic t_error;
        set_inputs(1'b0, 32'd5, 32'd100000, 32'd100000, 32'd100, 32'd60000,
                   32'd400000, 32'd100000, 32'd500000);
        pulse_start();
        wait_done();
        chk("R10", "err flag", err, 1);
        chk("R10", "lpx zero", lpx_cnt, 0);
        chk("R10", "wake zero", wake_lo, 0);
        chk("R10", "ta go zero", ta_go_cnt, 0);
        @(negedge clk);
    endtask

    // R11: a second start during busy must not change the result
    task automatic t_restart_ignored;
        set_inputs(1'b0, 32'd500000000, 32'd110000, 32'd150000, 32'd300,
                   32'd60000, 32'd400000, 32'd100000, 32'd500000);
        pulse_start();
        repeat (40) @(negedge clk);
        set_inputs(1'b1, 32'd2500000000, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done();
        check_result("R11 restart ignored", 1'b0, 32'd500000000, 32'd110000, 32'd150000,
                     32'd300, 32'd60000, 32'd400000, 32'd100000, 32'd500000,
                     0, 64'h20, 64'h1b, 64'h07, 64'h4e);
        repeat (3) @(negedge clk);
        chk("R11", "no second run", busy, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // R1 exact match on a row, low-rate variant
        run_case("R1 exact row", 1'b0, 32'd500000000, 32'd110000, 32'd150000, 32'd300,
                 32'd60000, 32'd400000, 32'd100000, 32'd500000,
                 0, 64'h20, 64'h1b, 64'h07, 64'h4e);
        // R1 above last row, LPX offset applied (R5)
        run_case("R1 above last row", 1'b0, 32'd1200000000, 32'd90000, 32'd70000, 32'd85,
                 32'd50000, 32'd300000, 32'd90000, 32'd450000,
                 0, 64'h09, 64'h20, 64'h09, 64'h27);
        // R1 below first row; R5 LPX ceil of 1 is kept
        run_case("R5 small lpx", 1'b0, 32'd100000000, 32'd200000, 32'd500000, 32'd8,
                 32'd50000, 32'd600000, 32'd120000, 32'd700000,
                 0, 64'h20, 64'h16, 64'h02, 64'h22);
        // R1 between rows, high-rate variant, LPX from table
        run_case("R1 between rows high", 1'b1, 32'd1500000000, 32'd100000, 32'd150000, 32'd129,
                 32'd999999, 32'd400000, 32'd100000, 32'd500000,
                 64'h0d, 64'h42, 64'h36, 64'h0e, 64'h0f);
        // R7 high fields set at top rate
        run_case("R7 high split", 1'b1, 32'd2500000000, 32'd100000, 32'd150000, 32'd64,
                 32'd1, 32'd250000, 32'd60000, 32'd310000,
                 64'h15, 64'h54, 64'h7f, 64'h15, 64'h6a);
        t_error();
        t_restart_ignored();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule